// File: doc/BRIEF.md
# Battery-Backed Memory Power Supervisor

This block is the digital supervisor of a battery-backed static memory. It receives three comparator results that describe the external supply: whether it sits above the tolerance trip point, above the battery switchover level, and above the battery's own voltage. From these it produces five outputs. The first is an active-low reset request, modelled as a drive-low enable for an open-drain pin. The others are a memory write-protect, a supply-versus-battery power select, a charger enable, and a sticky flag that marks the battery as connected after the first good supply.

All three flags are resynchronised with two-flop chains. Every output is registered, so any flag change reaches the outputs on the third rising clock edge. When the supply comes back, a single cycle counter times two intervals. The first is a recovery interval, after which writes are allowed again. The second is a longer reset interval, after which the processor reset is released. A dip below the trip point during either interval starts the whole sequence over.

Top module: `nvps_supervisor`

## Requirements
- R1: When `sup_ok_i` falls, `wr_protect_o` is 1 from the third rising edge after the change, and it stays 1 while the flag is low.
- R2: `batt_select_o` (1 = battery, 0 = external supply) equals the inverse of `sup_swo_i`, three rising edges after that flag changes.
- R3: After `sup_ok_i` rises, `wr_protect_o` drops to 0 on rising edge REC_CYC+3, counting the first edge after the change as edge 1.
- R4: `pull_low_o` (1 = reset line pulled low) is 1 whenever the supply is above the battery level but not fully running. It is 0 once `sup_batt_i` is low.
- R5: After `sup_ok_i` rises, `pull_low_o` drops to 0 on rising edge RST_CYC+3. RST_CYC must exceed REC_CYC, and elaboration fails otherwise. Write-protect is always released before reset.
- R6: If `sup_ok_i` falls during either interval, `wr_protect_o` and `pull_low_o` return to 1 and both intervals restart from zero on the next rise.
- R7: `batt_link_o` is 0 after reset. It becomes 1 together with the first rise of `charge_en_o` and stays 1 until the next asynchronous reset.
- R8: `charge_en_o` is 1 exactly while the synchronised trip flag is high, three rising edges after that flag changes.
- R9: While `arst_n` is low, the outputs read: `pull_low_o`=0, `wr_protect_o`=1, `batt_select_o`=1, `charge_en_o`=0, `batt_link_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| arst_n | input | 1 | Asynchronous active-low power-on reset |
| sup_ok_i | input | 1 | Supply above tolerance trip point |
| sup_swo_i | input | 1 | Supply above battery switchover level |
| sup_batt_i | input | 1 | Supply above battery voltage |
| pull_low_o | output | 1 | Drive-low enable of the open-drain reset request |
| wr_protect_o | output | 1 | Memory write-protect |
| batt_select_o | output | 1 | Memory power from battery (1) or supply (0) |
| charge_en_o | output | 1 | Battery charger enable |
| batt_link_o | output | 1 | Battery connected for backup (sticky) |

## Verification
Four relationships are checked by assertions on every clock cycle:
- a low trip flag forces write-protect on the next state;
- the battery select follows the switchover flag;
- the charger turns off after a trip and the battery link never clears;
- reset is never released while writes are still blocked.

The counter stays within its limit in every cycle. Three things appear only in the bench's scenarios: the exact edge on which each interval ends, the restart after a brief dip, and the steady output values for each combination of supply flags.

// File: rtl/nvps_pkg.sv
package nvps_pkg;

    typedef enum logic [1:0] {
        ST_DOWN    = 2'd0,
        ST_RECOVER = 2'd1,
        ST_RSTWAIT = 2'd2,
        ST_RUN     = 2'd3
    } nvps_state_e;

    typedef struct packed {
        nvps_state_e state;
        logic        pull;
        logic        wp;
        logic        sel;
        logic        chg;
        logic        link;
    } nvps_regs_t;

    localparam nvps_regs_t NVPS_RESET = '{
        state: ST_DOWN,
        pull:  1'b0,
        wp:    1'b1,
        sel:   1'b1,
        chg:   1'b0,
        link:  1'b0
    };

endpackage

// File: rtl/nvps_sync.sv
module nvps_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_q;
    logic [STAGES-1:0][W-1:0] chain_d;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q[g] <= '0;
                else         chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/nvps_timer.sv
module nvps_timer #(
    parameter int LIMIT = 64,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          clr_i,
    input  logic          en_i,
    output logic [CW-1:0] cnt_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                          cnt_d = '0;
        else if (en_i && cnt_q != CW'(LIMIT)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
        cnt_q <= CW'(LIMIT));                                   // R5
    AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!arst_n)
        clr_i |=> (cnt_q == '0));                               // R6

endmodule

// File: rtl/nvps_supervisor.sv
module nvps_supervisor
    import nvps_pkg::*;
#(
    parameter int REC_CYC = 16,
    parameter int RST_CYC = 48,
    localparam int CW     = $clog2(RST_CYC + 1)
) (
    input  logic clk,
    input  logic arst_n,
    input  logic sup_ok_i,
    input  logic sup_swo_i,
    input  logic sup_batt_i,
    output logic pull_low_o,
    output logic wr_protect_o,
    output logic batt_select_o,
    output logic charge_en_o,
    output logic batt_link_o
);

    generate
        if (REC_CYC < 1 || RST_CYC <= REC_CYC) begin : g_bad_timeouts
            $error("nvps_supervisor: RST_CYC must exceed REC_CYC, and REC_CYC must be at least 1");
        end
    endgenerate

    logic [2:0]    flags_s;
    logic          ok_s, swo_s, batt_s;
    logic [CW-1:0] cnt;
    logic          tmr_clr, tmr_en;
    nvps_regs_t    cur_q, nxt_d;

    nvps_sync #(.W(3), .STAGES(2)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d_i    ({sup_ok_i, sup_swo_i, sup_batt_i}),
        .q_o    (flags_s)
    );

    assign ok_s   = flags_s[2];
    assign swo_s  = flags_s[1];
    assign batt_s = flags_s[0];

    assign tmr_clr = !ok_s || (cur_q.state == ST_DOWN);
    assign tmr_en  = (cur_q.state == ST_RECOVER) || (cur_q.state == ST_RSTWAIT);

    nvps_timer #(.LIMIT(RST_CYC)) u_timer (
        .clk    (clk),
        .arst_n (arst_n),
        .clr_i  (tmr_clr),
        .en_i   (tmr_en),
        .cnt_o  (cnt)
    );

    always_comb begin
        nxt_d = cur_q;
        if (!ok_s) begin
            nxt_d.state = ST_DOWN;
        end else begin
            unique case (cur_q.state)
                ST_DOWN:    nxt_d.state = ST_RECOVER;
                ST_RECOVER: if (cnt == CW'(REC_CYC - 1)) nxt_d.state = ST_RSTWAIT;
                ST_RSTWAIT: if (cnt == CW'(RST_CYC - 1)) nxt_d.state = ST_RUN;
                ST_RUN:     nxt_d.state = ST_RUN;
                default:    nxt_d.state = ST_DOWN;
            endcase
        end
        nxt_d.wp   = (nxt_d.state == ST_DOWN) || (nxt_d.state == ST_RECOVER);
        nxt_d.pull = batt_s && (nxt_d.state != ST_RUN);
        nxt_d.sel  = !swo_s;
        nxt_d.chg  = (nxt_d.state != ST_DOWN);
        nxt_d.link = cur_q.link || ok_s;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cur_q <= NVPS_RESET;
        else         cur_q <= nxt_d;
    end

    assign pull_low_o    = cur_q.pull;
    assign wr_protect_o  = cur_q.wp;
    assign batt_select_o = cur_q.sel;
    assign charge_en_o   = cur_q.chg;
    assign batt_link_o   = cur_q.link;

    AST_WP_ON_TRIP: assert property (@(posedge clk) disable iff (!arst_n)
        !ok_s |=> wr_protect_o);                                // R1
    AST_SEL_FOLLOWS: assert property (@(posedge clk) disable iff (!arst_n)
        (swo_s |=> !batt_select_o) and (!swo_s |=> batt_select_o)); // R2
    AST_PULL_ON_TRIP: assert property (@(posedge clk) disable iff (!arst_n)
        (batt_s && !ok_s) |=> pull_low_o);                      // R4
    AST_WP_BEFORE_RST: assert property (@(posedge clk) disable iff (!arst_n)
        ($fell(pull_low_o) && charge_en_o) |-> !wr_protect_o);  // R5
    AST_LINK_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
        batt_link_o |=> batt_link_o);                           // R7
    AST_CHG_OFF: assert property (@(posedge clk) disable iff (!arst_n)
        !ok_s |=> !charge_en_o);                                // R8

endmodule

// File: tb/nvps_supervisor_test.sv
`timescale 1ns/1ps
module nvps_supervisor_test;

    localparam int REC = 8;
    localparam int RST = 20;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic ok_i = 1'b0, swo_i = 1'b0, bat_i = 1'b0;
    logic pull, wp, sel, chg, link;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    nvps_supervisor #(.REC_CYC(REC), .RST_CYC(RST)) uut (
        .clk           (clk),
        .arst_n        (arst_n),
        .sup_ok_i      (ok_i),
        .sup_swo_i     (swo_i),
        .sup_batt_i    (bat_i),
        .pull_low_o    (pull),
        .wr_protect_o  (wp),
        .batt_select_o (sel),
        .charge_en_o   (chg),
        .batt_link_o   (link)
    );

    // vector: [7:5] = {ok, swo, batt}; [4:0] = expected {pull, wp, sel, chg, link}
    localparam logic [7:0] VECS [0:7] = '{
        8'b011_1_1_0_0_0,
        8'b111_0_0_0_1_1,
        8'b011_1_1_0_0_1,
        8'b001_1_1_1_0_1,
        8'b000_0_1_1_0_1,
        8'b111_0_0_0_1_1,
        8'b010_0_1_0_0_1,
        8'b000_0_1_1_0_1
    };

    task automatic check(input string req, input logic got, input logic exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic [2:0] f);
        {ok_i, swo_i, bat_i} = f;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        // R9: reset state
        #12;
        @(negedge clk);
        check("R9", pull, 1'b0, "pull in reset");
        check("R9", wp,   1'b1, "wp in reset");
        check("R9", sel,  1'b1, "sel in reset");
        check("R9", chg,  1'b0, "chg in reset");
        check("R9", link, 1'b0, "link in reset");
        arst_n = 1'b1;
        edges(3);
        check("R7", link, 1'b0, "link before first good supply");

        // table walk: steady outputs for each flag pattern (R2 R4 R7 R8)
        for (int i = 0; i < 8; i++) begin
            drive(VECS[i][7:5]);
            edges(RST + 6);
            check("R4", pull, VECS[i][4], $sformatf("vec %0d pull", i));
            check("R1", wp,   VECS[i][3], $sformatf("vec %0d wp", i));
            check("R2", sel,  VECS[i][2], $sformatf("vec %0d sel", i));
            check("R8", chg,  VECS[i][1], $sformatf("vec %0d chg", i));
            check("R7", link, VECS[i][0], $sformatf("vec %0d link", i));
        end

        // R3 / R5: exact release edges
        drive(3'b011);
        edges(6);
        drive(3'b111);
        edges(2 + REC);
        check("R3", wp, 1'b1, "wp one edge before recovery end");
        edges(1);
        check("R3", wp, 1'b0, "wp at recovery end");
        check("R5", pull, 1'b1, "pull held after recovery");
        edges(RST - REC - 1);
        check("R5", pull, 1'b1, "pull one edge before reset end");
        edges(1);
        check("R5", pull, 1'b0, "pull at reset end");

        // R1 / R8: latency of the trip response
        drive(3'b011);
        edges(2);
        check("R1", wp, 1'b0, "wp before sync latency");
        edges(1);
        check("R1", wp, 1'b1, "wp on third edge");
        check("R8", chg, 1'b0, "chg off on third edge");
        check("R4", pull, 1'b1, "pull on trip");

        // R2: switchover latency
        drive(3'b001);
        edges(2);
        check("R2", sel, 1'b0, "sel before sync latency");
        edges(1);
        check("R2", sel, 1'b1, "sel to battery on third edge");
        drive(3'b011);
        edges(6);

        // R6: dip during recovery restarts the timing
        drive(3'b111);
        edges(REC - 1);
        drive(3'b011);
        edges(4);
        check("R6", wp, 1'b1, "wp during dip");
        drive(3'b111);
        edges(2 + REC);
        check("R6", wp, 1'b1, "wp before restarted recovery end");
        edges(1);
        check("R6", wp, 1'b0, "wp at restarted recovery end");

        // R6: dip during reset wait re-asserts protect and restarts reset
        edges(2);
        drive(3'b011);
        edges(3);
        check("R6", wp, 1'b1, "wp re-asserted in reset wait");
        check("R6", pull, 1'b1, "pull held in reset wait dip");
        edges(2);
        drive(3'b111);
        edges(2 + RST);
        check("R6", pull, 1'b1, "pull before restarted reset end");
        edges(1);
        check("R6", pull, 1'b0, "pull at restarted reset end");

        // R7 / R9: async reset clears the sticky link
        check("R7", link, 1'b1, "link set while running");
        #1 arst_n = 1'b0;
        #1;
        check("R9", link, 1'b0, "link cleared by reset");
        check("R9", wp, 1'b1, "wp forced by reset");
        @(negedge clk);
        arst_n = 1'b1;
        drive(3'b011);
        edges(RST + 6);
        check("R7", link, 1'b0, "link stays clear below trip");

        done = 1'b1;
        summary();
    end

endmodule